// File: doc/BRIEF.md
# Conversion Data-Ready Flag Controller

This block tells a host when a new periodic conversion result can be collected. The converter gives it a one-cycle strobe with each 24-bit result. A serial front end reports host activity as byte-access strobes and last-bit strobes, each with a byte index. The block holds the result that the host can see. It drives an active-low ready flag. It returns the byte that the host asked for.

The flag goes low when a fresh result appears. It goes high once the host has shifted out the final bit of the least significant byte. A result that arrives while the previous one is still unclaimed makes the flag rise for a fixed number of cycles and then fall again, so the host sees a new falling edge. A read that is already under way when a new result arrives keeps returning the old result. The new result waits in a pending register and becomes visible as soon as that read finishes.

Top module: `conv_ready_ctrl`

## Requirements
- R1: After synchronous reset, `rdy_n_o` is 1, `byte_o` is 0x00, and a read returns 0x00 in every byte.
- R2: A result strobe arriving while the flag is high and no pulse is running drives `rdy_n_o` low on the following cycle.
- R3: A last-bit strobe with index 2 (the least significant byte) ends the read and drives `rdy_n_o` high on the following cycle, cancelling any pulse in progress.
- R4: A last-bit strobe with index 0 or 1 leaves a low `rdy_n_o` low.
- R5: A result strobe arriving while `rdy_n_o` is low holds `rdy_n_o` high for exactly PULSE_W cycles, then drives it low.
- R6: A result strobe arriving during such a pulse restarts it, so the flag stays high for PULSE_W cycles counted from the latest strobe.
- R7: A byte-access strobe loads `byte_o` on the next cycle. Index 0 selects bits 23:16, index 1 selects bits 15:8, index 2 selects bits 7:0, and index 3 returns 0x00.
- R8: A read is in progress from a byte-access strobe until the index-2 last-bit strobe. A result arriving in that window does not change the bytes returned by that read.
- R9: When a read ends while a result is pending, the pending result becomes visible for the next read and `rdy_n_o` stays high.
- R10: If a result strobe and the index-2 last-bit strobe fall on the same cycle, the new result becomes visible and `rdy_n_o` goes low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid_i | input | 1 | One-cycle strobe marking a new conversion result |
| res_data_i | input | 24 | Conversion result, qualified by res_valid_i |
| acc_i | input | 1 | Host begins reading the byte selected by idx_i |
| lsb_i | input | 1 | Last bit of the byte selected by idx_i has been shifted out |
| idx_i | input | 2 | Byte index: 0 most significant, 2 least significant |
| rdy_n_o | output | 1 | Data-ready flag, active low |
| byte_o | output | 8 | Registered byte returned for the last access |

## Verification
Results are given to the block in four situations: with nothing outstanding, with an unread result in place, during a pulse that is already running, and in the middle of a multi-byte read. These separate the direct flag assertion, the pulse, the pulse restart, and the pending path. Full reads are compared against partial reads, and the partial reads end on the upper bytes. This shows that only the last bit of the lowest byte clears the flag. The case where a strobe and the read completion fall on the same cycle shows which one takes priority.

// File: rtl/conv_rdy_pkg.sv
package conv_rdy_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/conv_read_track.sv
// Tracks whether a host read sequence is under way and flags its completion.
module conv_read_track #(
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned LOW_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_i,
  input  logic             lsb_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             busy_o,
  output logic             done_o
);
  logic busy_q;

  assign done_o = lsb_i && (idx_i == IDX_W'(LOW_IDX));
  assign busy_o = busy_q || acc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (acc_i) begin
      busy_q <= 1'b1;
    end
  end

  // R3: completion ends the read window
  a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_q);
  // R8: an access opens the read window
  a_r8_acc_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !done_o) |=> busy_q);
endmodule

// File: rtl/conv_ready_flag.sv
// Active-low ready flag with a restartable fixed-width high pulse.
module conv_ready_flag #(
  parameter int unsigned PULSE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic res_valid_i,
  input  logic done_i,
  output logic rdy_n_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_W + 1);

  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulsing;

  assign pulsing = (cnt_q != '0);
  assign rdy_n_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_i) begin
      cnt_q  <= '0;
      flag_q <= !res_valid_i;
    end else if (res_valid_i) begin
      if (!flag_q || pulsing) begin
        cnt_q  <= CNT_W'(PULSE_W);
        flag_q <= 1'b1;
      end else begin
        flag_q <= 1'b0;
      end
    end else if (pulsing) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        flag_q <= 1'b0;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (flag_q && cnt_q == '0));
  a_r2_assert_when_idle: assert property (@(posedge clk) disable iff (rst)
    (res_valid_i && !done_i && flag_q && !pulsing) |=> !flag_q);
  a_r3_done_raises: assert property (@(posedge clk) disable iff (rst)
    (done_i && !res_valid_i) |=> (flag_q && cnt_q == '0));
  a_r5_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (res_valid_i && !done_i && (!flag_q || pulsing)) |=> (flag_q && cnt_q == CNT_W'(PULSE_W)));
  a_r5_pulse_end: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1) && !res_valid_i && !done_i) |=> !flag_q);
  a_r6_high_while_pulsing: assert property (@(posedge clk) disable iff (rst)
    pulsing |-> flag_q);
  a_r10_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (done_i && res_valid_i) |=> !flag_q);
endmodule

// File: rtl/conv_result_buf.sv
// Visible result register plus pending shadow, and registered byte selection.
module conv_result_buf
  import conv_rdy_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  output byte_t             byte_o
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] vis_q;
  logic [DATA_W-1:0] pend_q;
  logic              pend_v;
  byte_t             lane [NBYTES];
  byte_t             sel;
  byte_t             byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (done_i) begin
      pend_v <= 1'b0;
      if (res_valid_i) begin
        vis_q <= res_data_i;
      end else if (pend_v) begin
        vis_q <= pend_q;
      end
    end else if (res_valid_i) begin
      if (busy_i) begin
        pend_q <= res_data_i;
        pend_v <= 1'b1;
      end else begin
        vis_q <= res_data_i;
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = vis_q[DATA_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (idx_i == IDX_W'(k)) sel = lane[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
    end else if (acc_i) begin
      byte_q <= sel;
    end
  end

  assign byte_o = byte_q;

  // R8: visible data frozen while a read is open
  a_r8_hold_mid_read: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !done_i) |=> $stable(vis_q));
  a_r9_promote_pending: assert property (@(posedge clk) disable iff (rst)
    (done_i && !res_valid_i && pend_v) |=> (vis_q == $past(pend_q) && !pend_v));
  a_r10_new_wins: assert property (@(posedge clk) disable iff (rst)
    (done_i && res_valid_i) |=> (vis_q == $past(res_data_i) && !pend_v));
  a_r7_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_i |=> $stable(byte_q));
endmodule

// File: rtl/conv_ready_ctrl.sv
module conv_ready_ctrl
  import conv_rdy_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned PULSE_W = 4,
  localparam int unsigned NBYTES = DATA_W / BYTE_W,
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              acc_i,
  input  logic              lsb_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              rdy_n_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic busy;
  logic done;

  conv_read_track #(.IDX_W(IDX_W), .LOW_IDX(NBYTES - 1)) u_track (
    .clk(clk), .rst(rst), .acc_i(acc_i), .lsb_i(lsb_i), .idx_i(idx_i),
    .busy_o(busy), .done_o(done)
  );

  conv_ready_flag #(.PULSE_W(PULSE_W)) u_flag (
    .clk(clk), .rst(rst), .res_valid_i(res_valid_i), .done_i(done),
    .rdy_n_o(rdy_n_o)
  );

  conv_result_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .busy_i(busy), .done_i(done), .acc_i(acc_i), .idx_i(idx_i),
    .byte_o(byte_o)
  );

  // R4: last bit of an upper byte leaves an asserted flag asserted
  a_r4_upper_lsb_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (lsb_i && idx_i != IDX_W'(NBYTES - 1) && !res_valid_i && !rdy_n_o) |=> !rdy_n_o);
endmodule

// File: tb/sim_conv_ready_ctrl.sv
module sim_conv_ready_ctrl;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rv = 1'b0;
  logic [23:0] rdat = '0;
  logic        acc = 1'b0;
  logic        lsb = 1'b0;
  logic [1:0]  idx = '0;
  logic        rdy_n;
  logic [7:0]  bo;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic acc_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  conv_ready_ctrl #(.DATA_W(24), .PULSE_W(PW)) u0 (
    .clk(clk), .rst(rst), .res_valid_i(rv), .res_data_i(rdat),
    .acc_i(acc), .lsb_i(lsb), .idx_i(idx), .rdy_n_o(rdy_n), .byte_o(bo)
  );

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] ex);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, ex);
    end
  endtask

  // scoreboard monitor: byte_o is compared one edge after each access
  always @(posedge clk) acc_seen <= acc && !rst;
  always @(negedge clk) begin
    if (acc_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", {24'h0, bo}, 32'h0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bo == e, t, {24'h0, bo}, {24'h0, e});
      end
    end
  end

  task automatic put(input logic [23:0] d);
    rv = 1'b1; rdat = d;
    @(negedge clk);
    rv = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ix, input logic [7:0] ex, input string tg);
    exp_q.push_back(ex); tag_q.push_back(tg);
    acc = 1'b1; idx = ix;
    @(negedge clk);
    acc = 1'b0; lsb = 1'b1;
    @(negedge clk);
    lsb = 1'b0;
  endtask

  task automatic rd_all(input logic [23:0] d, input string tg);
    rd(2'd0, d[23:16], tg);
    rd(2'd1, d[15:8], tg);
    rd(2'd2, d[7:0], tg);
  endtask

  task automatic chk_pulse(input string tg);
    for (int i = 0; i < PW; i++) begin
      chk(rdy_n == 1'b1, tg, {31'h0, rdy_n}, 32'h1);
      @(negedge clk);
    end
    chk(rdy_n == 1'b0, tg, {31'h0, rdy_n}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(rdy_n == 1'b1, "R1 flag after reset", {31'h0, rdy_n}, 32'h1);
    chk(bo == 8'h00, "R1 byte after reset", {24'h0, bo}, 32'h0);
    rd_all(24'h000000, "R1 empty read");
    chk(rdy_n == 1'b1, "R1 flag after empty read", {31'h0, rdy_n}, 32'h1);

    // R2, R4, R3, R7: plain full read
    put(24'hA1B2C3);
    chk(rdy_n == 1'b0, "R2 assert on fresh result", {31'h0, rdy_n}, 32'h0);
    rd(2'd0, 8'hA1, "R7 idx0");
    chk(rdy_n == 1'b0, "R4 idx0 lsb keeps low", {31'h0, rdy_n}, 32'h0);
    rd(2'd1, 8'hB2, "R7 idx1");
    chk(rdy_n == 1'b0, "R4 idx1 lsb keeps low", {31'h0, rdy_n}, 32'h0);
    rd(2'd3, 8'h00, "R7 idx3 zero");
    rd(2'd2, 8'hC3, "R7 idx2");
    chk(rdy_n == 1'b1, "R3 deassert at low-byte lsb", {31'h0, rdy_n}, 32'h1);

    // R5: missed result pulses
    put(24'h112233);
    chk(rdy_n == 1'b0, "R2 assert again", {31'h0, rdy_n}, 32'h0);
    put(24'h445566);
    chk_pulse("R5 missed-result pulse");
    rd_all(24'h445566, "R5 newest result read");
    chk(rdy_n == 1'b1, "R3 after pulse read", {31'h0, rdy_n}, 32'h1);

    // R6: restart during pulse
    put(24'h778899);
    put(24'hAABBCC);
    @(negedge clk);
    @(negedge clk);
    put(24'hDDEEFF);
    chk_pulse("R6 pulse restart");
    rd_all(24'hDDEEFF, "R6 read after restart");

    // R8, R9: result lands mid-read
    put(24'h135790);
    rd(2'd0, 8'h13, "R8 old hi");
    put(24'h2468AC);
    rd(2'd1, 8'h57, "R8 old mid");
    rd(2'd2, 8'h90, "R8 old lo");
    chk(rdy_n == 1'b1, "R9 high at lsb of old data", {31'h0, rdy_n}, 32'h1);
    for (int i = 0; i < PW + 2; i++) begin
      @(negedge clk);
      chk(rdy_n == 1'b1, "R9 stays high", {31'h0, rdy_n}, 32'h1);
    end
    rd_all(24'h2468AC, "R9 pending now visible");
    chk(rdy_n == 1'b1, "R9 high after pending read", {31'h0, rdy_n}, 32'h1);

    // R10: completion and new result on the same cycle
    put(24'h0F1E2D);
    rd(2'd0, 8'h0F, "R10 first hi");
    rd(2'd1, 8'h1E, "R10 first mid");
    exp_q.push_back(8'h2D); tag_q.push_back("R10 first lo");
    acc = 1'b1; idx = 2'd2;
    @(negedge clk);
    acc = 1'b0; lsb = 1'b1; rv = 1'b1; rdat = 24'h3C4B5A;
    @(negedge clk);
    lsb = 1'b0; rv = 1'b0;
    chk(rdy_n == 1'b0, "R10 flag low after coincidence", {31'h0, rdy_n}, 32'h0);
    rd_all(24'h3C4B5A, "R10 new result visible");
    chk(rdy_n == 1'b1, "R3 final read", {31'h0, rdy_n}, 32'h1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule